// File: doc/BRIEF.md
# Six-Input Rotating Priority Arbiter

The block chooses one winner among six request lines. Line 0 always wins when it is active, and line 5 wins only when no other line is active. The four lines in between are ranked by one of four cyclic orders, picked by a 2-bit select value. The grant is combinational from the current requests and the current select value. It is presented three ways: a one-hot vector, a valid flag and a binary index.

The select value is held in a register that resets to 00. In fixed mode, only an explicit write changes it. In rotate mode, each service strobe that lands on a granted middle line moves the select value. The serviced line then drops to the lowest rank among the middle four, which spreads service evenly among those four lines.

Top module: `rot_arb6`

## Requirements
- R1: After reset is released, `sel_o` is 00.
- R2: When `req_i[0]` is high it is granted whatever the other lines and the select value are. `req_i[5]` is granted only when lines 0 to 4 are all low.
- R3: When line 0 is low, the middle lines are ranked from highest to lowest by `sel_o`. The order is 1,2,3,4 for 00, then 2,3,4,1 for 01, then 3,4,1,2 for 10, then 4,1,2,3 for 11. The highest-ranked active middle line is granted.
- R4: Bit i of `gnt_o` is set for the granted line i, and `gnt_idx_o` equals i. At most one grant bit is high. `gnt_vld_o` is high exactly when some request is high. With no request, `gnt_o` is 0 and `gnt_idx_o` is 0.
- R5: With `rot_en_i` low and no write, `sel_o` keeps its value across a clock edge, including when `serve_i` is high.
- R6: With `rot_en_i` high, a clock edge with `serve_i` high loads a new select value, derived from the index granted in that same cycle. Index 1 loads 01, index 2 loads 10, index 3 loads 11 and index 4 loads 00.
- R7: In rotate mode, servicing line 0 or line 5 leaves `sel_o` unchanged.
- R8: A service strobe while no request is active leaves `sel_o` unchanged.
- R9: A clock edge with `sel_wr_i` high loads `sel_wdata_i` into the select value. This holds in either mode and overrides any automatic update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 6 | Request lines; bit i is line i |
| serve_i | input | 1 | Service strobe for the current grant |
| rot_en_i | input | 1 | 1 selects rotate mode, 0 selects fixed mode |
| sel_wr_i | input | 1 | Write strobe for the select value |
| sel_wdata_i | input | 2 | Select value to write |
| gnt_o | output | 6 | One-hot grant |
| gnt_vld_o | output | 1 | A request is granted |
| gnt_idx_o | output | 3 | Index of the granted line |
| sel_o | output | 2 | Current select value |

## Verification
A write to the select value and an automatic rotation after service can fall in the same clock edge. The stimulus provokes this with a randomized write strobe that often coincides with a service strobe in rotate mode, while several middle lines are active. A directed case forces the same collision with a written value that differs from the one the rotation would load. The select output after that edge is judged against a bench model: the written value must win, and the rotation target must be discarded.

// File: rtl/rot_arb_pkg.sv
package rot_arb_pkg;
  localparam int unsigned NUM_REQ = 6;
  localparam int unsigned MID_N   = NUM_REQ - 2;
  localparam int unsigned SEL_W   = $clog2(MID_N);
  localparam int unsigned IDX_W   = $clog2(NUM_REQ);
  localparam int unsigned TOP_IDX = 0;
  localparam int unsigned BOT_IDX = NUM_REQ - 1;

  typedef logic [NUM_REQ-1:0] req_t;
  typedef logic [SEL_W-1:0]   sel_t;
  typedef logic [IDX_W-1:0]   idx_t;
endpackage

// File: rtl/rot_arb_pick.sv
module rot_arb_pick
  import rot_arb_pkg::*;
(
  input  req_t req_i,
  input  sel_t sel_i,
  output req_t gnt_o,
  output logic vld_o,
  output idx_t idx_o
);
  logic found;
  int unsigned pos;

  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    found = 1'b0;
    pos   = 0;
    if (req_i[TOP_IDX]) begin
      idx_o = idx_t'(TOP_IDX);
      found = 1'b1;
    end else begin
      // middle lines: rotating window starting at sel+1
      for (int unsigned k = 0; k < MID_N; k++) begin
        pos = 32'(sel_i) + k;
        pos = 1 + (pos % MID_N);
        if (!found && req_i[pos]) begin
          idx_o = idx_t'(pos);
          found = 1'b1;
        end
      end
      if (!found && req_i[BOT_IDX]) begin
        idx_o = idx_t'(BOT_IDX);
        found = 1'b1;
      end
    end
    if (found) gnt_o[idx_o] = 1'b1;
    vld_o = found;
  end
endmodule

// File: rtl/rot_arb_sel.sv
module rot_arb_sel
  import rot_arb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rot_en_i,
  input  logic serve_i,
  input  logic vld_i,
  input  idx_t idx_i,
  input  logic wr_i,
  input  sel_t wdata_i,
  output sel_t sel_o
);
  sel_t sel_q, sel_d;
  logic mid_hit;

  assign mid_hit = (idx_i != idx_t'(TOP_IDX)) && (idx_i != idx_t'(BOT_IDX));

  always_comb begin
    sel_d = sel_q;
    if (wr_i)
      sel_d = wdata_i;
    else if (rot_en_i && serve_i && vld_i && mid_hit)
      sel_d = sel_t'(idx_i);  // idx 1..MID_N wraps, so MID_N maps to 0
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else         sel_q <= sel_d;
  end

  assign sel_o = sel_q;

  assert_wr_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> sel_o == $past(wdata_i));

  assert_fixed_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rot_en_i && !wr_i) |=> $stable(sel_o));

  assert_edge_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rot_en_i && serve_i && !wr_i && vld_i &&
     (idx_i == idx_t'(TOP_IDX) || idx_i == idx_t'(BOT_IDX))) |=> $stable(sel_o));

  assert_idle_serve_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (serve_i && !vld_i && !wr_i) |=> $stable(sel_o));

  assert_rot_to_last_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rot_en_i && serve_i && !wr_i && vld_i && idx_i == idx_t'(1)) |=> sel_o == sel_t'(1));
endmodule

// File: rtl/rot_arb6.sv
module rot_arb6
  import rot_arb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [5:0]       req_i,
  input  logic             serve_i,
  input  logic             rot_en_i,
  input  logic             sel_wr_i,
  input  logic [1:0]       sel_wdata_i,
  output logic [5:0]       gnt_o,
  output logic             gnt_vld_o,
  output logic [2:0]       gnt_idx_o,
  output logic [1:0]       sel_o
);
  sel_t sel;
  req_t gnt;
  idx_t idx;
  logic vld;

  rot_arb_pick u_pick (
    .req_i (req_i),
    .sel_i (sel),
    .gnt_o (gnt),
    .vld_o (vld),
    .idx_o (idx)
  );

  rot_arb_sel u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rot_en_i(rot_en_i),
    .serve_i (serve_i),
    .vld_i   (vld),
    .idx_i   (idx),
    .wr_i    (sel_wr_i),
    .wdata_i (sel_wdata_i),
    .sel_o   (sel)
  );

  assign gnt_o     = gnt;
  assign gnt_vld_o = vld;
  assign gnt_idx_o = idx;
  assign sel_o     = sel;

  assert_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o) && (gnt_vld_o == (|req_i)));

  assert_idx_match_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_vld_o |-> gnt_o[gnt_idx_o]);

  assert_top_wins_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i[0] |-> (gnt_o == 6'b000001));

  assert_bottom_last_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_o[5] |-> (req_i[4:0] == 5'b0));
endmodule

// File: tb/sim_rot_arb6.sv
`timescale 1ns/1ps
module sim_rot_arb6;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] req = '0;
  logic       serve = 1'b0, rot = 1'b0, wr = 1'b0;
  logic [1:0] wd = '0;
  logic [5:0] gnt;
  logic       vld;
  logic [2:0] idx;
  logic [1:0] sel;

  int checks = 0, errors = 0;
  logic [1:0] sel_m = 2'b00;
  bit done = 0;

  always #2.5 clk = ~clk;

  rot_arb6 u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .serve_i(serve), .rot_en_i(rot),
    .sel_wr_i(wr), .sel_wdata_i(wd), .gnt_o(gnt), .gnt_vld_o(vld),
    .gnt_idx_o(idx), .sel_o(sel)
  );

  function automatic int exp_idx(logic [5:0] r, logic [1:0] s);
    int ord[4];
    if (r[0]) return 0;
    case (s)
      2'b00: ord = '{1, 2, 3, 4};
      2'b01: ord = '{2, 3, 4, 1};
      2'b10: ord = '{3, 4, 1, 2};
      default: ord = '{4, 1, 2, 3};
    endcase
    for (int k = 0; k < 4; k++) if (r[ord[k]]) return ord[k];
    if (r[5]) return 5;
    return -1;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // drive at negedge, check grant, clock once, check select
  task automatic step(logic [5:0] r, logic sv, logic ro, logic w, logic [1:0] d);
    int e;
    logic [5:0] eg;
    logic [1:0] nxt;
    string tg, ts;
    req = r; serve = sv; rot = ro; wr = w; wd = d;
    #1;
    e  = exp_idx(r, sel_m);
    eg = (e < 0) ? 6'b0 : (6'b1 << e);
    if (r == 6'b0) tg = "R4";
    else if (r[0] || e == 5) tg = "R2";
    else tg = "R3";
    chk(gnt == eg, tg, "gnt_o", int'(gnt), int'(eg));
    chk(idx == ((e < 0) ? 3'd0 : 3'(e)), "R4", "gnt_idx_o", int'(idx), (e < 0) ? 0 : e);
    chk(vld == (e >= 0), "R4", "gnt_vld_o", int'(vld), int'(e >= 0));
    nxt = sel_m;
    if (w) begin nxt = d; ts = "R9"; end
    else if (!ro) ts = "R5";
    else if (!sv) ts = "R5";
    else if (e < 0) ts = "R8";
    else if (e == 0 || e == 5) ts = "R7";
    else begin
      ts = "R6";
      case (e)
        1: nxt = 2'b01;
        2: nxt = 2'b10;
        3: nxt = 2'b11;
        default: nxt = 2'b00;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    chk(sel == nxt, ts, "sel_o", int'(sel), int'(nxt));
    sel_m = nxt;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sel == 2'b00, "R1", "sel_o after reset", int'(sel), 0);
    // full rotation walk, all middle lines busy
    for (int n = 0; n < 5; n++) step(6'b011110, 1, 1, 0, 2'b00);
    // fixed orders selected by write
    for (int s = 0; s < 4; s++) begin
      step(6'b000000, 0, 0, 1, 2'(s));
      step(6'b011110, 1, 0, 0, 2'b00);
      step(6'b100110, 1, 0, 0, 2'b00);
    end
    // edge lines serviced in rotate mode
    step(6'b111111, 1, 1, 0, 2'b00);
    step(6'b100000, 1, 1, 0, 2'b00);
    // service with nothing requested
    step(6'b000000, 1, 1, 0, 2'b00);
    // write collides with rotation, different target
    step(6'b000010, 1, 1, 1, 2'b11);
    step(6'b010000, 1, 1, 1, 2'b10);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] r;
      r = 6'($urandom);
      if ($urandom % 4 == 0) r[0] = 1'b0;
      if ($urandom % 3 == 0) r[4:0] = 5'b0;
      step(r, 1'($urandom % 3 != 0), 1'($urandom % 4 != 0),
           1'($urandom % 6 == 0), 2'($urandom));
    end
    finish_run();
  end
endmodule